// File: doc/BRIEF.md
# Per-Second Packet Loss Performance Monitor

This block watches the packet stream arriving at the receive side of a constant-bit-rate circuit emulation link. It is told of every received packet, of every packet found missing, and whether each received packet carries the remote-defect flag. It also takes the packet-loss defect from the playout logic. A one-cycle tick marks the end of each one-second interval. At each tick the block judges the second that has just closed. It keeps a degradation defect that is raised from a run of seconds whose loss ratio is above a configured threshold. It keeps counters of errored, severely errored and unavailable seconds, and a far-end counter of seconds in which the remote-defect flag was seen.

Unavailable time is handled with hysteresis. A run of severely errored seconds that turns out to start an unavailable period is taken back from the errored and severely errored counts and added to unavailable time. A run of clean seconds that ends such a period is taken back from unavailable time, and its errored seconds are added to the errored count. The block holds each candidate run in shadow counters until that run resolves, so it never needs to store a history of seconds. Loss ratios are compared by cross-multiplication, so no divider is needed.

Top module: `pm_loss_monitor`

## Requirements
- R1: Received and lost packets are counted per second. An event in the same cycle as `sec_tick` belongs to the second that is closing, and the count starts again from zero after the tick.
- R2: A second is "over threshold" when lost×100 > `cfg_sd_pct`×(lost+received). `deg_defect` rises at the tick that closes the `cfg_deg_secs`-th consecutive over-threshold second. It falls at the tick of the first second that is not over threshold. It changes only on a tick.
- R3: A second is errored when it has at least one lost packet, or when `plos_in` is high at its tick, or when `deg_defect` is high at its tick (the value before that tick updates it).
- R4: A second is severely errored when lost×100 > 15×(lost+received), or when the defect condition of R3 holds.
- R5: A second with no lost packets and no active defect is error-free, whether or not any packets arrived.
- R6: When `unavail` is low and `cfg_uas_enter` consecutive severely errored seconds close, `unavail` rises. `uas_count` grows by `cfg_uas_enter`, and none of the seconds in that run is added to `es_count` or `ses_count`.
- R7: While `unavail` is high, `ses_count` does not change. Each second that does not end the period adds one to `uas_count`.
- R8: While `unavail` is high, `cfg_uas_exit` consecutive seconds that are not severely errored make `unavail` fall. `uas_count` is then reduced by `cfg_uas_exit`−1, so that none of the clearing seconds remains counted as unavailable. The errored seconds in the clearing run are added to `es_count`.
- R9: When `unavail` is low and a run of severely errored seconds shorter than `cfg_uas_enter` is ended by a second that is not severely errored, the run is added to both `es_count` and `ses_count`. The ending second is added to `es_count` if it is errored.
- R10: `fe_count` grows by one for each second in which at least one cycle has `pkt_rx` and `pkt_rdi` both high. A `pkt_rdi` pulse without `pkt_rx` has no effect.
- R11: After reset all counters and both defect outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse that closes the current second |
| pkt_rx | input | 1 | One packet received this cycle |
| pkt_lost | input | 1 | One packet declared lost this cycle |
| pkt_rdi | input | 1 | Received packet carries the remote-defect flag (qualified by pkt_rx) |
| plos_in | input | 1 | Packet-loss defect from the playout logic |
| cfg_sd_pct | input | 7 | Degradation loss-ratio threshold in percent |
| cfg_deg_secs | input | 4 | Consecutive over-threshold seconds needed for degradation |
| cfg_uas_enter | input | 5 | Consecutive severely errored seconds that start unavailable time |
| cfg_uas_exit | input | 5 | Consecutive non-severe seconds that end unavailable time |
| deg_defect | output | 1 | Degradation defect |
| unavail | output | 1 | Unavailable state |
| es_count | output | 32 | Errored seconds |
| ses_count | output | 32 | Severely errored seconds |
| uas_count | output | 32 | Unavailable seconds |
| fe_count | output | 32 | Seconds with remote-defect flag seen |

## Verification
The hardest situation to reach is the interaction between the hysteresis runs and the defect feedback. A degradation defect makes the following clean seconds severely errored, and those seconds can then extend a run into unavailable time, while a clearing run can contain errored seconds that are not severe. Directed seconds first build exact runs one short of entry, then exactly at entry, then a clearing run with a lightly lossy second inside it. After that a long stretch of random loss patterns under a second configuration runs against a behavioural per-second model, which compares every output on every clock.

// File: rtl/pm_loss_pkg.sv
package pm_loss_pkg;
    // fixed loss ratio, in percent, that marks a severely errored second
    localparam int unsigned SES_PCT = 15;

    typedef enum logic {
        ST_AVAIL   = 1'b0,
        ST_UNAVAIL = 1'b1
    } avail_st_e;
endpackage

// File: rtl/pm_sec_accum.sv
module pm_sec_accum #(
    parameter int PKT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             pkt_rx,
    input  logic             pkt_lost,
    input  logic             pkt_rdi,
    output logic [PKT_W-1:0] sec_lost,
    output logic [PKT_W-1:0] sec_rx,
    output logic             sec_rdi
);
    typedef struct packed {
        logic [PKT_W-1:0] lost;
        logic [PKT_W-1:0] rx;
        logic             rdi;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        // totals include this cycle's events so a tick-cycle event is not lost
        sec_lost = (acc_q.lost == '1) ? acc_q.lost : acc_q.lost + PKT_W'(pkt_lost);
        sec_rx   = (acc_q.rx == '1)   ? acc_q.rx   : acc_q.rx + PKT_W'(pkt_rx);
        sec_rdi  = acc_q.rdi | (pkt_rx & pkt_rdi);
        if (sec_tick) begin
            acc_d = '0;
        end else begin
            acc_d.lost = sec_lost;
            acc_d.rx   = sec_rx;
            acc_d.rdi  = sec_rdi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R1: a new second starts from an empty count
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (acc_q.lost == '0 && acc_q.rx == '0 && !acc_q.rdi));
endmodule

// File: rtl/pm_ratio_cmp.sv
module pm_ratio_cmp #(
    parameter int PKT_W = 16,
    parameter int PCT_W = 7
) (
    input  logic [PKT_W-1:0] lost,
    input  logic [PKT_W-1:0] rx,
    input  logic [PCT_W-1:0] pct,
    output logic             over
);
    localparam int PROD_W = PKT_W + 1 + PCT_W + 1;

    logic [PROD_W-1:0] lhs;
    logic [PROD_W-1:0] rhs;

    always_comb begin
        lhs  = PROD_W'(lost) * PROD_W'(100);
        rhs  = (PROD_W'(lost) + PROD_W'(rx)) * PROD_W'(pct);
        over = lhs > rhs;
    end
endmodule

// File: rtl/pm_deg_detect.sv
module pm_deg_detect #(
    parameter int DEG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             over,
    input  logic [DEG_W-1:0] cfg_deg_secs,
    output logic             deg
);
    typedef struct packed {
        logic [DEG_W-1:0] run;
        logic             deg;
    } deg_t;

    deg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sec_tick) begin
            if (over) s_d.run = (s_q.run == '1) ? s_q.run : s_q.run + 1'b1;
            else      s_d.run = '0;
            s_d.deg = over && (s_d.run >= cfg_deg_secs);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign deg = s_q.deg;

    // R2: the defect moves only at a second boundary
    a_r2_deg_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(s_q.deg));
endmodule

// File: rtl/pm_avail_tracker.sv
module pm_avail_tracker
    import pm_loss_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             es_sec,
    input  logic             ses_sec,
    input  logic [RUN_W-1:0] cfg_enter,
    input  logic [RUN_W-1:0] cfg_exit,
    output logic             unavail,
    output logic [CNT_W-1:0] es_count,
    output logic [CNT_W-1:0] ses_count,
    output logic [CNT_W-1:0] uas_count
);
    typedef struct packed {
        avail_st_e        st;
        logic [RUN_W-1:0] run;
        logic [RUN_W-1:0] shadow_es;
        logic [CNT_W-1:0] es;
        logic [CNT_W-1:0] ses;
        logic [CNT_W-1:0] uas;
    } trk_t;

    trk_t s_d, s_q;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        s_d     = s_q;
        run_inc = s_q.run + 1'b1;
        if (sec_tick) begin
            if (s_q.st == ST_AVAIL) begin
                if (ses_sec) begin
                    if (run_inc == cfg_enter) begin
                        // run confirmed: pending seconds become unavailable
                        s_d.st        = ST_UNAVAIL;
                        s_d.uas       = s_q.uas + CNT_W'(cfg_enter);
                        s_d.run       = '0;
                        s_d.shadow_es = '0;
                    end else begin
                        s_d.run       = run_inc;
                        s_d.shadow_es = s_q.shadow_es + 1'b1;
                    end
                end else begin
                    // run broken: commit the pending seconds
                    s_d.es        = s_q.es + CNT_W'(s_q.shadow_es) + CNT_W'(es_sec);
                    s_d.ses       = s_q.ses + CNT_W'(s_q.run);
                    s_d.run       = '0;
                    s_d.shadow_es = '0;
                end
            end else begin
                if (ses_sec) begin
                    s_d.uas       = s_q.uas + 1'b1;
                    s_d.run       = '0;
                    s_d.shadow_es = '0;
                end else if (run_inc == cfg_exit) begin
                    // clearing confirmed: take the clearing seconds back
                    s_d.st        = ST_AVAIL;
                    s_d.uas       = s_q.uas - (CNT_W'(cfg_exit) - 1'b1);
                    s_d.es        = s_q.es + CNT_W'(s_q.shadow_es) + CNT_W'(es_sec);
                    s_d.run       = '0;
                    s_d.shadow_es = '0;
                end else begin
                    s_d.uas       = s_q.uas + 1'b1;
                    s_d.run       = run_inc;
                    s_d.shadow_es = s_q.shadow_es + RUN_W'(es_sec);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_AVAIL;
        end else begin
            s_q <= s_d;
        end
    end

    assign unavail   = (s_q.st == ST_UNAVAIL);
    assign es_count  = s_q.es;
    assign ses_count = s_q.ses;
    assign uas_count = s_q.uas;

    // R6: entry only on a closing severely errored second
    a_r6_entry_on_ses: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unavail) |-> $past(sec_tick && ses_sec));
    // R8: exit only on a closing second that is not severely errored
    a_r8_exit_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unavail) |-> $past(sec_tick && !ses_sec));
    // R7: no severe seconds are counted while unavailable
    a_r7_ses_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        unavail |=> $stable(s_q.ses));
    // R3: the errored count never goes backwards
    a_r3_es_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.es >= $past(s_q.es));
endmodule

// File: rtl/pm_loss_monitor.sv
module pm_loss_monitor
    import pm_loss_pkg::*;
#(
    parameter int PKT_W = 16,
    parameter int CNT_W = 32,
    parameter int PCT_W = 7,
    parameter int DEG_W = 4,
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic             pkt_rx,
    input  logic             pkt_lost,
    input  logic             pkt_rdi,
    input  logic             plos_in,
    input  logic [PCT_W-1:0] cfg_sd_pct,
    input  logic [DEG_W-1:0] cfg_deg_secs,
    input  logic [RUN_W-1:0] cfg_uas_enter,
    input  logic [RUN_W-1:0] cfg_uas_exit,
    output logic             deg_defect,
    output logic             unavail,
    output logic [CNT_W-1:0] es_count,
    output logic [CNT_W-1:0] ses_count,
    output logic [CNT_W-1:0] uas_count,
    output logic [CNT_W-1:0] fe_count
);
    logic [PKT_W-1:0] sec_lost;
    logic [PKT_W-1:0] sec_rx;
    logic             sec_rdi;
    logic             sd_over;
    logic             ses_over;
    logic             defect;
    logic             es_sec;
    logic             ses_sec;
    logic [CNT_W-1:0] fe_d, fe_q;

    pm_sec_accum #(.PKT_W(PKT_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .pkt_rx(pkt_rx), .pkt_lost(pkt_lost), .pkt_rdi(pkt_rdi),
        .sec_lost(sec_lost), .sec_rx(sec_rx), .sec_rdi(sec_rdi)
    );

    pm_ratio_cmp #(.PKT_W(PKT_W), .PCT_W(PCT_W)) sd_cmp_i (
        .lost(sec_lost), .rx(sec_rx), .pct(cfg_sd_pct), .over(sd_over)
    );

    pm_ratio_cmp #(.PKT_W(PKT_W), .PCT_W(PCT_W)) ses_cmp_i (
        .lost(sec_lost), .rx(sec_rx), .pct(PCT_W'(SES_PCT)), .over(ses_over)
    );

    pm_deg_detect #(.DEG_W(DEG_W)) deg_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .over(sd_over), .cfg_deg_secs(cfg_deg_secs), .deg(deg_defect)
    );

    always_comb begin
        // defect state as it stood while the second was running
        defect  = plos_in | deg_defect;
        es_sec  = (sec_lost != '0) | defect;
        ses_sec = ses_over | defect;
        fe_d    = fe_q + CNT_W'(sec_tick & sec_rdi);
    end

    pm_avail_tracker #(.CNT_W(CNT_W), .RUN_W(RUN_W)) trk_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .es_sec(es_sec), .ses_sec(ses_sec),
        .cfg_enter(cfg_uas_enter), .cfg_exit(cfg_uas_exit),
        .unavail(unavail), .es_count(es_count),
        .ses_count(ses_count), .uas_count(uas_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) fe_q <= '0;
        else        fe_q <= fe_d;
    end

    assign fe_count = fe_q;

    // R10: at most one far-end second per tick, none between ticks
    a_r10_fe_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q - $past(fe_q)) <= CNT_W'($past(sec_tick)));
    // R11: counters hold zero right after reset
    a_r11_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (fe_q == '0 && es_count == '0 && uas_count == '0));
endmodule

// File: tb/pm_loss_monitor_tb_top.sv
module pm_loss_monitor_tb_top;
    localparam int SEC_LEN = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0, pkt_rx = 1'b0, pkt_lost = 1'b0, pkt_rdi = 1'b0, plos_in = 1'b0;
    logic [6:0]  cfg_sd_pct = 7'd15;
    logic [3:0]  cfg_deg_secs = 4'd3;
    logic [4:0]  cfg_uas_enter = 5'd3;
    logic [4:0]  cfg_uas_exit = 5'd2;
    logic        deg_defect, unavail;
    logic [31:0] es_count, ses_count, uas_count, fe_count;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // reference state
    int m_lost, m_rx, m_es, m_ses, m_uas, m_fe, m_run, m_shadow, m_degrun;
    bit m_rdi, m_deg, m_unav;

    always #4 clk = ~clk;

    pm_loss_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .pkt_rx(pkt_rx),
        .pkt_lost(pkt_lost), .pkt_rdi(pkt_rdi), .plos_in(plos_in),
        .cfg_sd_pct(cfg_sd_pct), .cfg_deg_secs(cfg_deg_secs),
        .cfg_uas_enter(cfg_uas_enter), .cfg_uas_exit(cfg_uas_exit),
        .deg_defect(deg_defect), .unavail(unavail), .es_count(es_count),
        .ses_count(ses_count), .uas_count(uas_count), .fe_count(fe_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_lost = 0; m_rx = 0; m_es = 0; m_ses = 0; m_uas = 0; m_fe = 0;
        m_run = 0; m_shadow = 0; m_degrun = 0; m_rdi = 0; m_deg = 0; m_unav = 0;
    endtask

    task automatic model_step();
        bit sd, sr, dfct, es, ses;
        m_lost += int'(pkt_lost);
        m_rx   += int'(pkt_rx);
        if (pkt_rx && pkt_rdi) m_rdi = 1;
        if (sec_tick) begin
            sd   = (m_lost * 100) > (int'(cfg_sd_pct) * (m_lost + m_rx));
            sr   = (m_lost * 100) > (15 * (m_lost + m_rx));
            dfct = plos_in || m_deg;
            es   = (m_lost > 0) || dfct;
            ses  = sr || dfct;
            if (m_rdi) m_fe++;
            m_degrun = sd ? ((m_degrun < 15) ? m_degrun + 1 : 15) : 0;
            m_deg    = sd && (m_degrun >= int'(cfg_deg_secs));
            if (!m_unav) begin
                if (ses) begin
                    m_run++;
                    if (m_run == int'(cfg_uas_enter)) begin
                        m_unav = 1; m_uas += m_run; m_run = 0; m_shadow = 0;
                    end
                end else begin
                    m_es += m_run + int'(es); m_ses += m_run; m_run = 0;
                end
            end else begin
                if (ses) begin
                    m_uas++; m_run = 0; m_shadow = 0;
                end else begin
                    m_run++;
                    m_shadow += int'(es);
                    if (m_run == int'(cfg_uas_exit)) begin
                        m_unav = 0; m_uas -= (m_run - 1); m_es += m_shadow;
                        m_run = 0; m_shadow = 0;
                    end else begin
                        m_uas++;
                    end
                end
            end
            m_lost = 0; m_rx = 0; m_rdi = 0;
        end
    endtask

    task automatic compare();
        check(deg_defect == m_deg, "R2 deg_defect", int'(deg_defect), int'(m_deg));
        check(unavail == m_unav, "R6 R8 unavail", int'(unavail), int'(m_unav));
        check(es_count == 32'(m_es), "R1 R3 R5 R9 es_count", int'(es_count), m_es);
        check(ses_count == 32'(m_ses), "R4 R7 R9 ses_count", int'(ses_count), m_ses);
        check(uas_count == 32'(m_uas), "R6 R7 R8 uas_count", int'(uas_count), m_uas);
        check(fe_count == 32'(m_fe), "R10 fe_count", int'(fe_count), m_fe);
    endtask

    task automatic cycle(input bit tk, input bit rx, input bit ls, input bit rd);
        sec_tick = tk; pkt_rx = rx; pkt_lost = ls; pkt_rdi = rd;
        @(posedge clk);
        model_step();
        #1 compare();
    endtask

    // one second; events sit at the end so the tick cycle carries one (R1)
    task automatic second(input int nrx, input int nlost, input bit rdi, input bit plos);
        plos_in = plos;
        for (int i = 0; i < SEC_LEN; i++)
            cycle(i == SEC_LEN - 1, i >= SEC_LEN - nrx, i >= SEC_LEN - nlost,
                  rdi && (i == SEC_LEN - 1));
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check(es_count == 0 && ses_count == 0 && uas_count == 0 && fe_count == 0
              && !deg_defect && !unavail, "R11 reset", int'(es_count), 0);
        rst_n = 1'b1;

        // R5: empty and clean seconds
        second(0, 0, 0, 0);
        second(10, 0, 0, 0);
        // R10: flagged second, then rdi without rx is ignored
        second(10, 0, 1, 0);
        plos_in = 0;
        for (int i = 0; i < SEC_LEN; i++) cycle(i == SEC_LEN - 1, 0, 0, 1);
        // R3: light loss gives ES only
        second(10, 1, 0, 0);
        // R9: short SES runs committed
        second(10, 3, 0, 0);
        second(10, 0, 0, 0);
        second(10, 3, 0, 0);
        second(10, 3, 0, 0);
        second(10, 1, 0, 0);
        // R2 R6: degradation and entry into unavailable time
        second(10, 3, 0, 0);
        second(10, 3, 0, 0);
        second(10, 3, 0, 0);
        second(10, 0, 0, 0);
        // R7: plos keeps it unavailable
        second(10, 0, 0, 1);
        second(10, 0, 0, 1);
        // R8: clearing run with a lightly errored second
        second(10, 1, 0, 0);
        second(10, 0, 0, 0);
        second(10, 0, 0, 0);

        // second configuration, random patterns
        cfg_sd_pct = 7'd40; cfg_deg_secs = 4'd2;
        cfg_uas_enter = 5'd5; cfg_uas_exit = 5'd4;
        for (int s = 0; s < 300; s++) begin
            int r = int'($urandom_range(0, 9));
            second(int'($urandom_range(0, 12)), (r < 4) ? int'($urandom_range(0, 12)) : 0,
                   bit'($urandom_range(0, 1)), r == 9);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule